// File: doc/BRIEF.md
# Parity-Protected Two-Way Instruction Cache Lookup

This block is the lookup stage of a small two-way set-associative instruction cache. Tags and line data sit in flop arrays. Every stored tag carries one even parity bit over the whole tag. Every line is cut into fixed-size granules, and each granule carries its own even parity bit. A lookup compares the request tag against both ways of the indexed set. When nothing is wrong, the result appears on the cycle after the request is accepted, which is the same latency as a cache without protection.

If a lookup finds a parity mismatch in the indexed set, the block does not report a fault. The mismatch may be in the tag of any valid way or in a data granule of the way that hit. The block holds off the requester for one cycle and clears the valid bits of both ways in that set. It then returns the access as a miss. The normal miss/refill handshake then fetches the line again from the next level. An error strobe and a saturating event counter make these recoveries visible.

Refill writes compute the parity again for the tag and for every granule. A per-bit flip mask on the refill port lets chosen stored parity bits be inverted, which models a corrupted bitcell.

Top module: `icp_lookup`

## Requirements
- R1: A lookup hits when a valid way of the indexed set holds the request tag (request address = {tag, index}, index in the low IDX_W bits) and no parity error is seen. On the cycle after acceptance, resp_valid=1, resp_hit=1 and resp_data equals the stored line, and req_ready stays 1.
- R2: A lookup with no valid matching way and no parity error returns resp_valid=1 and resp_hit=0 on the cycle after acceptance. In that same cycle, miss_valid rises with miss_addr equal to the request address, and req_ready stays 0 while miss_valid is 1.
- R3: A refill_valid pulse while miss_valid is 1 writes the tag and line of miss_addr into the set. The way chosen is the lower-numbered invalid way if there is one; otherwise a per-set pointer picks the way, starting at way 0 after reset and alternating on each such refill. The written way becomes valid, and miss_valid clears and req_ready returns on the next cycle.
- R4: Each tag is stored with one even parity bit over its 31 bits. A mismatch in any valid way of the indexed set is a parity error, whether or not that way matches.
- R5: Each line is stored with one even parity bit per 18-bit granule. Only the granules of the hit way are checked, so a corrupted granule in a way that did not hit does not cause an error.
- R6: When a lookup detects a parity error, the cycle after acceptance has resp_valid=0 and req_ready=0. The cycle after that has resp_valid=1, resp_hit=0, miss_valid=1 with miss_addr equal to the request address, and both ways of the set invalid.
- R7: After a parity recovery, every tag that was held in that set misses until it is refilled again.
- R8: err_pulse is 1 for exactly one cycle per detected error: the cycle after the erroneous request is accepted.
- R9: err_count increases by one on the cycle after each err_pulse and holds at 2^CNT_W-1 once it reaches it.
- R10: After reset, all ways are invalid, req_ready=1, resp_valid=0, miss_valid=0, err_pulse=0 and err_count=0.
- R11: refill_par_flip inverts stored parity on a refill: bit 0 inverts the tag parity, and bit 1+g inverts the parity of data granule g.
- R12: refill_valid while miss_valid is 0 is ignored: no way becomes valid and no response is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Lookup request |
| req_addr | input | TAG_W+IDX_W | Lookup address {tag, index} |
| req_ready | output | 1 | Lookup can be accepted |
| resp_valid | output | 1 | Lookup result strobe |
| resp_hit | output | 1 | Result is a hit |
| resp_data | output | GRAN_W*GRANS | Line returned on a hit |
| miss_valid | output | 1 | Refill request outstanding |
| miss_addr | output | TAG_W+IDX_W | Address to be refilled |
| refill_valid | input | 1 | Refill line present |
| refill_line | input | GRAN_W*GRANS | Refill line data |
| refill_par_flip | input | GRANS+1 | Stored-parity inversion mask for the refill |
| err_pulse | output | 1 | One-cycle parity error event |
| err_count | output | CNT_W | Saturating parity error event count |

## Verification
The bench builds the block with IDX_W=2 and CNT_W=3, keeping the 31-bit tag and 4×18-bit granule defaults. Four sets make tag conflicts, full sets and pointer-driven replacement frequent under random addresses drawn from a small tag pool. A three-bit counter reaches saturation after a handful of injected errors, and directed cases add clean hits beside a corrupted way and repeated corrupted refills.

// File: rtl/icp_pkg.sv
package icp_pkg;
  typedef enum logic [0:0] {
    ST_LOOK  = 1'b0,
    ST_INVAL = 1'b1
  } icp_state_e;
endpackage

// File: rtl/icp_parity_gen.sv
// Even parity per granule: N granules of W bits each.
module icp_parity_gen #(
  parameter int W = 18,
  parameter int N = 4
) (
  input  logic [W*N-1:0] data,
  output logic [N-1:0]   par
);
  for (genvar g = 0; g < N; g++) begin : g_gran
    assign par[g] = ^data[g*W +: W];
  end
endmodule

// File: rtl/icp_way_store.sv
// One way: tag, tag parity, line, granule parity and valid bits.
module icp_way_store #(
  parameter int IDX_W  = 6,
  parameter int TAG_W  = 31,
  parameter int GRAN_W = 18,
  parameter int GRANS  = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [IDX_W-1:0]         rd_idx,
  input  logic                     wr_en,
  input  logic [IDX_W-1:0]         wr_idx,
  input  logic [TAG_W-1:0]         wr_tag,
  input  logic [GRAN_W*GRANS-1:0]  wr_line,
  input  logic [GRANS:0]           wr_flip,
  input  logic                     inv_en,
  input  logic [IDX_W-1:0]         inv_idx,
  output logic [TAG_W-1:0]         rd_tag,
  output logic                     rd_tpar,
  output logic [GRAN_W*GRANS-1:0]  rd_line,
  output logic [GRANS-1:0]         rd_lpar,
  output logic [(1<<IDX_W)-1:0]    vld_vec
);
  localparam int SETS   = 1 << IDX_W;
  localparam int LINE_W = GRAN_W * GRANS;

  logic [TAG_W-1:0]  tag_q  [SETS];
  logic              tpar_q [SETS];
  logic [LINE_W-1:0] line_q [SETS];
  logic [GRANS-1:0]  lpar_q [SETS];
  logic [SETS-1:0]   vld_q, vld_d;
  logic [0:0]        tpar_w;
  logic [GRANS-1:0]  lpar_w;

  icp_parity_gen #(.W(TAG_W), .N(1)) u_tag_par (
    .data (wr_tag),
    .par  (tpar_w)
  );

  icp_parity_gen #(.W(GRAN_W), .N(GRANS)) u_line_par (
    .data (wr_line),
    .par  (lpar_w)
  );

  // Storage arrays carry no reset; only the valid bits are reset.
  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_q[wr_idx]  <= wr_tag;
      tpar_q[wr_idx] <= tpar_w[0] ^ wr_flip[0];
      line_q[wr_idx] <= wr_line;
      lpar_q[wr_idx] <= lpar_w ^ wr_flip[GRANS:1];
    end
  end

  always_comb begin
    vld_d = vld_q;
    if (inv_en) vld_d[inv_idx] = 1'b0;
    if (wr_en)  vld_d[wr_idx]  = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else        vld_q <= vld_d;
  end

  assign rd_tag  = tag_q[rd_idx];
  assign rd_tpar = tpar_q[rd_idx];
  assign rd_line = line_q[rd_idx];
  assign rd_lpar = lpar_q[rd_idx];
  assign vld_vec = vld_q;

  // R3
  refill_sets_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> vld_q[$past(wr_idx)]);

  // R6
  inval_clears_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inv_en && !wr_en |=> !vld_q[$past(inv_idx)]);
endmodule

// File: rtl/icp_check.sv
// Tag compare and parity checks across both ways of the indexed set.
module icp_check #(
  parameter int TAG_W  = 31,
  parameter int GRAN_W = 18,
  parameter int GRANS  = 4
) (
  input  logic [TAG_W-1:0]                req_tag,
  input  logic [1:0]                      vld,
  input  logic [1:0][TAG_W-1:0]           tag,
  input  logic [1:0]                      tpar,
  input  logic [1:0][GRAN_W*GRANS-1:0]    line,
  input  logic [1:0][GRANS-1:0]           lpar,
  output logic                            hit,
  output logic [GRAN_W*GRANS-1:0]         hit_line,
  output logic                            err
);
  logic [1:0] match, tag_bad, data_bad;
  logic       err_data;

  for (genvar w = 0; w < 2; w++) begin : g_way
    logic [GRANS-1:0] pg;
    icp_parity_gen #(.W(GRAN_W), .N(GRANS)) u_chk_par (
      .data (line[w]),
      .par  (pg)
    );
    assign match[w]    = vld[w] && (tag[w] == req_tag);
    assign tag_bad[w]  = vld[w] && ((^tag[w]) != tpar[w]);
    assign data_bad[w] = |(pg ^ lpar[w]);
  end

  always_comb begin
    hit      = |match;
    hit_line = match[0] ? line[0] : line[1];
    if (match[0])      err_data = data_bad[0];
    else if (match[1]) err_data = data_bad[1];
    else               err_data = 1'b0;
    err = (|tag_bad) | err_data;
  end
endmodule

// File: rtl/icp_ctrl.sv
// Request/response sequencing, recovery cycle, miss tracking, victim pointers
// and the error event counter.
module icp_ctrl
  import icp_pkg::*;
#(
  parameter int IDX_W  = 6,
  parameter int TAG_W  = 31,
  parameter int LINE_W = 72,
  parameter int CNT_W  = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         req_valid,
  input  logic [TAG_W+IDX_W-1:0]       req_addr,
  output logic                         req_ready,
  input  logic                         lk_hit,
  input  logic [LINE_W-1:0]            lk_line,
  input  logic                         lk_err,
  input  logic [1:0][(1<<IDX_W)-1:0]   vld_vec,
  input  logic                         refill_valid,
  output logic                         resp_valid,
  output logic                         resp_hit,
  output logic [LINE_W-1:0]            resp_data,
  output logic                         miss_valid,
  output logic [TAG_W+IDX_W-1:0]       miss_addr,
  output logic [1:0]                   wr_en,
  output logic                         inv_en,
  output logic                         err_pulse,
  output logic [CNT_W-1:0]             err_count
);
  localparam int ADDR_W = TAG_W + IDX_W;
  localparam int SETS   = 1 << IDX_W;
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  icp_state_e        state_q, state_d;
  logic              miss_q, miss_d;
  logic [ADDR_W-1:0] maddr_q, maddr_d;
  logic              rv_q, rv_d, hit_q, hit_d, err_q, err_d;
  logic [LINE_W-1:0] data_q, data_d;
  logic              data_en;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [SETS-1:0]   ptr_q, ptr_d;
  logic [IDX_W-1:0]  midx;
  logic              req_fire, refill_fire, v0, v1;

  assign req_ready   = (state_q == ST_LOOK) && !miss_q;
  assign req_fire    = req_valid && req_ready;
  assign refill_fire = refill_valid && miss_q;
  assign midx        = maddr_q[IDX_W-1:0];
  assign v0          = vld_vec[0][midx];
  assign v1          = vld_vec[1][midx];

  always_comb begin
    state_d = state_q;
    miss_d  = miss_q;
    maddr_d = maddr_q;
    rv_d    = 1'b0;
    hit_d   = 1'b0;
    err_d   = 1'b0;
    data_en = 1'b0;
    data_d  = data_q;
    cnt_d   = cnt_q;
    ptr_d   = ptr_q;
    inv_en  = 1'b0;
    wr_en   = 2'b00;

    if (err_q && (cnt_q != CNT_MAX)) cnt_d = cnt_q + 1'b1;

    unique case (state_q)
      ST_LOOK: begin
        if (req_fire) begin
          maddr_d = req_addr;
          if (lk_err) begin
            state_d = ST_INVAL;
            err_d   = 1'b1;
          end else begin
            rv_d    = 1'b1;
            hit_d   = lk_hit;
            data_en = 1'b1;
            data_d  = lk_hit ? lk_line : '0;
            miss_d  = !lk_hit;
          end
        end
        if (refill_fire) begin
          miss_d = 1'b0;
          if (!v0)      wr_en = 2'b01;
          else if (!v1) wr_en = 2'b10;
          else begin
            wr_en       = ptr_q[midx] ? 2'b10 : 2'b01;
            ptr_d[midx] = !ptr_q[midx];
          end
        end
      end
      ST_INVAL: begin
        inv_en  = 1'b1;
        rv_d    = 1'b1;
        data_en = 1'b1;
        data_d  = '0;
        miss_d  = 1'b1;
        state_d = ST_LOOK;
      end
      default: state_d = ST_LOOK;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_LOOK;
      miss_q  <= 1'b0;
      maddr_q <= '0;
      rv_q    <= 1'b0;
      hit_q   <= 1'b0;
      err_q   <= 1'b0;
      cnt_q   <= '0;
      ptr_q   <= '0;
    end else begin
      state_q <= state_d;
      miss_q  <= miss_d;
      maddr_q <= maddr_d;
      rv_q    <= rv_d;
      hit_q   <= hit_d;
      err_q   <= err_d;
      cnt_q   <= cnt_d;
      ptr_q   <= ptr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       data_q <= '0;
    else if (data_en) data_q <= data_d;
  end

  assign resp_valid = rv_q;
  assign resp_hit   = hit_q;
  assign resp_data  = data_q;
  assign miss_valid = miss_q;
  assign miss_addr  = maddr_q;
  assign err_pulse  = err_q;
  assign err_count  = cnt_q;

  // R6
  inval_ready_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    state_q == ST_INVAL |-> !req_ready);

  // R6
  inval_forces_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    state_q == ST_INVAL |=> resp_valid && !resp_hit && miss_valid);

  // R8
  err_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse |=> !err_pulse);

  // R9
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse && (err_count != CNT_MAX) |=> err_count == $past(err_count) + 1'b1);

  // R9
  cnt_saturate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_count == CNT_MAX |=> err_count == CNT_MAX);

  // R1
  hit_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resp_hit |-> resp_valid && !miss_valid);

  // R3
  refill_clears_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    miss_valid && refill_valid |=> !miss_valid);

  // R12
  stray_refill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !miss_valid |-> wr_en == 2'b00);
endmodule

// File: rtl/icp_lookup.sv
// Top: two way stores, the set checker and the controller.
module icp_lookup #(
  parameter int IDX_W  = 6,
  parameter int TAG_W  = 31,
  parameter int GRAN_W = 18,
  parameter int GRANS  = 4,
  parameter int CNT_W  = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       req_valid,
  input  logic [TAG_W+IDX_W-1:0]     req_addr,
  output logic                       req_ready,
  output logic                       resp_valid,
  output logic                       resp_hit,
  output logic [GRAN_W*GRANS-1:0]    resp_data,
  output logic                       miss_valid,
  output logic [TAG_W+IDX_W-1:0]     miss_addr,
  input  logic                       refill_valid,
  input  logic [GRAN_W*GRANS-1:0]    refill_line,
  input  logic [GRANS:0]             refill_par_flip,
  output logic                       err_pulse,
  output logic [CNT_W-1:0]           err_count
);
  localparam int LINE_W = GRAN_W * GRANS;
  localparam int SETS   = 1 << IDX_W;

  logic [IDX_W-1:0]            req_idx, miss_idx;
  logic [TAG_W-1:0]            req_tag, miss_tag;
  logic [1:0][TAG_W-1:0]       rd_tag;
  logic [1:0]                  rd_tpar, rd_vld;
  logic [1:0][LINE_W-1:0]      rd_line;
  logic [1:0][GRANS-1:0]       rd_lpar;
  logic [1:0][SETS-1:0]        vld_vec;
  logic [1:0]                  wr_en;
  logic                        inv_en, lk_hit, lk_err;
  logic [LINE_W-1:0]           lk_line;

  assign req_idx  = req_addr[IDX_W-1:0];
  assign req_tag  = req_addr[TAG_W+IDX_W-1:IDX_W];
  assign miss_idx = miss_addr[IDX_W-1:0];
  assign miss_tag = miss_addr[TAG_W+IDX_W-1:IDX_W];

  for (genvar w = 0; w < 2; w++) begin : g_way
    icp_way_store #(
      .IDX_W(IDX_W), .TAG_W(TAG_W), .GRAN_W(GRAN_W), .GRANS(GRANS)
    ) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .rd_idx  (req_idx),
      .wr_en   (wr_en[w]),
      .wr_idx  (miss_idx),
      .wr_tag  (miss_tag),
      .wr_line (refill_line),
      .wr_flip (refill_par_flip),
      .inv_en  (inv_en),
      .inv_idx (miss_idx),
      .rd_tag  (rd_tag[w]),
      .rd_tpar (rd_tpar[w]),
      .rd_line (rd_line[w]),
      .rd_lpar (rd_lpar[w]),
      .vld_vec (vld_vec[w])
    );
    assign rd_vld[w] = vld_vec[w][req_idx];
  end

  icp_check #(.TAG_W(TAG_W), .GRAN_W(GRAN_W), .GRANS(GRANS)) u_check (
    .req_tag  (req_tag),
    .vld      (rd_vld),
    .tag      (rd_tag),
    .tpar     (rd_tpar),
    .line     (rd_line),
    .lpar     (rd_lpar),
    .hit      (lk_hit),
    .hit_line (lk_line),
    .err      (lk_err)
  );

  icp_ctrl #(
    .IDX_W(IDX_W), .TAG_W(TAG_W), .LINE_W(LINE_W), .CNT_W(CNT_W)
  ) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_addr     (req_addr),
    .req_ready    (req_ready),
    .lk_hit       (lk_hit),
    .lk_line      (lk_line),
    .lk_err       (lk_err),
    .vld_vec      (vld_vec),
    .refill_valid (refill_valid),
    .resp_valid   (resp_valid),
    .resp_hit     (resp_hit),
    .resp_data    (resp_data),
    .miss_valid   (miss_valid),
    .miss_addr    (miss_addr),
    .wr_en        (wr_en),
    .inv_en       (inv_en),
    .err_pulse    (err_pulse),
    .err_count    (err_count)
  );
endmodule

// File: tb/tb_icp_lookup.sv
module tb_icp_lookup;
  localparam int IDX_W  = 2;
  localparam int TAG_W  = 31;
  localparam int GRAN_W = 18;
  localparam int GRANS  = 4;
  localparam int CNT_W  = 3;
  localparam int SETS   = 1 << IDX_W;
  localparam int LINE_W = GRAN_W * GRANS;
  localparam int ADDR_W = TAG_W + IDX_W;
  localparam int CMAX   = (1 << CNT_W) - 1;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req_valid = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic              req_ready, resp_valid, resp_hit, miss_valid, err_pulse;
  logic [LINE_W-1:0] resp_data;
  logic [ADDR_W-1:0] miss_addr;
  logic              refill_valid = 1'b0;
  logic [LINE_W-1:0] refill_line = '0;
  logic [GRANS:0]    refill_par_flip = '0;
  logic [CNT_W-1:0]  err_count;

  int checks = 0;
  int errors = 0;
  int exp_cnt = 0;

  logic              m_vld  [2][SETS];
  logic [TAG_W-1:0]  m_tag  [2][SETS];
  logic [LINE_W-1:0] m_line [2][SETS];
  logic              m_tcor [2][SETS];
  logic              m_dcor [2][SETS];
  logic              m_ptr  [SETS];

  always #10 clk = ~clk;

  icp_lookup #(
    .IDX_W(IDX_W), .TAG_W(TAG_W), .GRAN_W(GRAN_W), .GRANS(GRANS), .CNT_W(CNT_W)
  ) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_ready(req_ready), .resp_valid(resp_valid), .resp_hit(resp_hit),
    .resp_data(resp_data), .miss_valid(miss_valid), .miss_addr(miss_addr),
    .refill_valid(refill_valid), .refill_line(refill_line),
    .refill_par_flip(refill_par_flip), .err_pulse(err_pulse), .err_count(err_count)
  );

  task automatic chk(input bit ok, input string rq, input logic [127:0] act,
                     input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  function automatic logic [TAG_W-1:0] tpool(input int k);
    return TAG_W'(32'h9E37_79B9 * (k + 1));
  endfunction

  function automatic logic [GRANS:0] rand_flip();
    if ($urandom % 6 == 0) return (GRANS+1)'(1) << ($urandom % (GRANS + 1));
    return '0;
  endfunction

  task automatic do_refill(input logic [TAG_W-1:0] t, input logic [IDX_W-1:0] ix,
                           input logic [GRANS:0] flip);
    logic [LINE_W-1:0] ln;
    int w;
    ln = LINE_W'({$urandom(), $urandom(), $urandom()});
    refill_valid = 1'b1;
    refill_line = ln;
    refill_par_flip = flip;
    @(negedge clk);
    refill_valid = 1'b0;
    refill_par_flip = '0;
    chk(!miss_valid, "R3 miss_valid cleared after refill", 128'(miss_valid), 0);
    chk(req_ready, "R3 req_ready back after refill", 128'(req_ready), 1);
    if (!m_vld[0][ix]) w = 0;
    else if (!m_vld[1][ix]) w = 1;
    else begin
      w = int'(m_ptr[ix]);
      m_ptr[ix] = !m_ptr[ix];
    end
    m_vld[w][ix]  = 1'b1;
    m_tag[w][ix]  = t;
    m_line[w][ix] = ln;
    m_tcor[w][ix] = flip[0];
    m_dcor[w][ix] = |flip[GRANS:1];
  endtask

  task automatic do_lookup(input logic [TAG_W-1:0] t, input logic [IDX_W-1:0] ix,
                           input logic [GRANS:0] flip, output bit got_hit);
    bit h0, h1, terr, derr;
    int hw;
    string en;
    h0 = m_vld[0][ix] && (m_tag[0][ix] == t);
    h1 = !h0 && m_vld[1][ix] && (m_tag[1][ix] == t);
    terr = (m_vld[0][ix] && m_tcor[0][ix]) || (m_vld[1][ix] && m_tcor[1][ix]);
    derr = h0 ? m_dcor[0][ix] : (h1 ? m_dcor[1][ix] : 1'b0);
    en = terr ? "R4" : "R5";
    @(negedge clk);
    req_valid = 1'b1;
    req_addr  = {t, ix};
    @(negedge clk);
    req_valid = 1'b0;
    got_hit = 1'b0;
    if (terr || derr) begin
      chk(!resp_valid, "R6 no response in recovery cycle", 128'(resp_valid), 0);
      chk(!req_ready, "R6 ready low in recovery cycle", 128'(req_ready), 0);
      chk(err_pulse, {en, "/R8 err_pulse on detected error"}, 128'(err_pulse), 1);
      if (exp_cnt < CMAX) exp_cnt++;
      @(negedge clk);
      chk(resp_valid && !resp_hit, "R6 forced miss response",
          128'({resp_valid, resp_hit}), 128'(2'b10));
      chk(miss_valid && miss_addr == {t, ix}, "R6 miss raised after recovery",
          128'(miss_addr), 128'({t, ix}));
      chk(!err_pulse, "R8 err_pulse one cycle", 128'(err_pulse), 0);
      chk(err_count == CNT_W'(exp_cnt), "R9 error count", 128'(err_count), 128'(exp_cnt));
      m_vld[0][ix] = 1'b0;
      m_vld[1][ix] = 1'b0;
      do_refill(t, ix, flip);
    end else if (h0 || h1) begin
      hw = h0 ? 0 : 1;
      got_hit = 1'b1;
      chk(resp_valid && resp_hit, "R1 hit response",
          128'({resp_valid, resp_hit}), 128'(2'b11));
      chk(resp_data == m_line[hw][ix], "R1 hit data", 128'(resp_data),
          128'(m_line[hw][ix]));
      chk(req_ready && !err_pulse, "R1/R5 ready kept and no error on clean hit",
          128'({req_ready, err_pulse}), 128'(2'b10));
    end else begin
      chk(resp_valid && !resp_hit, "R2 miss response",
          128'({resp_valid, resp_hit}), 128'(2'b10));
      chk(miss_valid && miss_addr == {t, ix}, "R2 miss address",
          128'(miss_addr), 128'({t, ix}));
      chk(!req_ready, "R2 ready low while miss outstanding", 128'(req_ready), 0);
      do_refill(t, ix, flip);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    bit h;
    void'($urandom(32'd20240611));
    for (int s = 0; s < SETS; s++) begin
      m_ptr[s] = 1'b0;
      for (int w = 0; w < 2; w++) begin
        m_vld[w][s] = 1'b0; m_tcor[w][s] = 1'b0; m_dcor[w][s] = 1'b0;
        m_tag[w][s] = '0; m_line[w][s] = '0;
      end
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk(req_ready, "R10 ready after reset", 128'(req_ready), 1);
    chk(!resp_valid && !miss_valid && !err_pulse, "R10 outputs idle after reset",
        128'({resp_valid, miss_valid, err_pulse}), 0);
    chk(err_count == '0, "R10 count zero after reset", 128'(err_count), 0);

    // R12 stray refill ignored
    refill_valid = 1'b1;
    refill_line = '1;
    @(negedge clk);
    refill_valid = 1'b0;
    chk(!resp_valid && !miss_valid, "R12 stray refill produces nothing",
        128'({resp_valid, miss_valid}), 0);
    do_lookup('0, '0, '0, h);
    chk(!h, "R12 stray refill left set invalid", 128'(h), 0);

    // R5: corrupted granule in the way that does not hit is ignored
    do_lookup(tpool(0), 2'd1, '0, h);
    do_lookup(tpool(1), 2'd1, (GRANS+1)'(1) << 2, h);
    do_lookup(tpool(0), 2'd1, '0, h);
    chk(h, "R5 hit beside corrupted way", 128'(h), 1);
    // R4/R5 error on corrupted hit way, then R7 both ways gone
    do_lookup(tpool(1), 2'd1, '0, h);
    do_lookup(tpool(0), 2'd1, '0, h);
    chk(!h, "R7 other way cleared by recovery", 128'(h), 0);

    // R3 replacement pointer on a full set
    do_lookup(tpool(2), 2'd2, '0, h);
    do_lookup(tpool(3), 2'd2, '0, h);
    do_lookup(tpool(4), 2'd2, '0, h);
    do_lookup(tpool(3), 2'd2, '0, h);
    chk(h, "R3 way 1 kept by pointer", 128'(h), 1);
    do_lookup(tpool(2), 2'd2, '0, h);
    chk(!h, "R3 way 0 replaced first", 128'(h), 0);

    // R11 tag parity flip on refill, repeated to saturate R9
    for (int i = 0; i < CMAX + 2; i++) begin
      do_lookup(tpool(5), 2'd3, (GRANS+1)'(1), h);
      do_lookup(tpool(5), 2'd3, (GRANS+1)'(1), h);
    end
    chk(err_count == CNT_W'(CMAX), "R9 count saturated", 128'(err_count), 128'(CMAX));

    // random mix
    for (int n = 0; n < 400; n++) begin
      do_lookup(tpool($urandom % 6), IDX_W'($urandom), rand_flip(), h);
    end

    repeat (2) @(negedge clk);
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule